// File: doc/BRIEF.md
# Fan Spin-Up and Failure Supervisor

This block watches a fan during start-up and reports when the fan has failed. It compares every fan period measurement against a limit. A period above the limit means the fan turns too slowly. When that happens, the block takes over the PWM duty cycle and runs a spin-up. During a spin-up the duty climbs in a straight line from one third to full over the first third of a programmable interval. The duty then stays at full for the rest of the interval. At the end of the interval the duty drops back to one third and waits there for the next measurement.

A measurement that is still too slow after a spin-up counts as a failed attempt. After five failed attempts in a row, the active-low fault output goes low, provided faults are enabled. Spin-up attempts then keep repeating without limit. Any measurement that is back in range clears the count and releases the fault output. A sticky slow-fan flag shows software that a slow condition or a spin-up has happened. A status read clears the flag. The tach period counter and the normal fan control loops live outside this block and are not part of it.

Top module: `fan_spinup_supervisor`

## Requirements
- R1: After reset the block is in a spin-up: `ovr_sel`=1, `duty_ovr`=0x55, `slow_flag`=1, `fault_n`=1. This holds whatever the value of `spin_disable`.
- R2: The spin-up interval is counted in `ms_tick` pulses. Codes 0 to 7 of `spin_code` give 200, 400, 600, 800, 1000, 2000, 4000 and 8000 ticks.
- R3: Let e be the number of ticks since spin-up began and L the interval length. Let R = L/3, using integer division. While e < R, `duty_ovr` = 0x55 + (170*e)/R, again using integer division. For the rest of the interval `duty_ovr` is 0xFF.
- R4: The cycle after the final tick of the interval, `duty_ovr` = 0x55 with `ovr_sel`=1. This holds until the next measurement. If that measurement is in range, `ovr_sel` drops to 0 and `duty_ovr` goes to 0x00.
- R5: A measurement strobe that arrives during a spin-up is ignored. It does not set `slow_flag` and it does not change the duty.
- R6: A measurement is slow when `tach_period` > `slow_limit`, compared as unsigned values. A slow measurement taken outside a spin-up sets `slow_flag`. If `spin_disable`=0, it also starts a new spin-up, so the cycle after the strobe shows `ovr_sel`=1 and `duty_ovr`=0x55.
- R7: When `spin_disable`=1, a slow measurement starts no spin-up, and `ovr_sel` stays 0 or drops to 0.
- R8: A pulse on `status_read` clears `slow_flag`. If a slow measurement arrives in the same cycle as the read, the flag stays set.
- R9: A slow measurement that arrives while the block waits after a spin-up counts as one failed attempt. On the fifth failed attempt in a row, `fault_n` goes low if `fault_en`=1. A new spin-up still starts.
- R10: A measurement in range clears the count of failed attempts and releases `fault_n` to 1. A slow measurement taken after an in-range one does not count as a failed attempt.
- R11: `fault_n` is 1 whenever `fault_en`=0. If `fault_en` is set again while the count of failed attempts is still at five, `fault_n` goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| meas_valid | input | 1 | Strobe: a new tach period is present |
| tach_period | input | TACH_W | Measured fan period; larger means a slower fan |
| slow_limit | input | TACH_W | The fan counts as slow when the period is above this value |
| spin_code | input | 3 | Selects the spin-up interval length |
| spin_disable | input | 1 | Blocks spin-ups triggered by slow measurements |
| fault_en | input | 1 | Allows `fault_n` to go low |
| status_read | input | 1 | Read pulse that clears `slow_flag` |
| duty_ovr | output | 8 | Override duty cycle (0x55 = 33.3%, 0xFF = 100%) |
| ovr_sel | output | 1 | When 1, `duty_ovr` replaces the normal loop's duty |
| slow_flag | output | 1 | Sticky slow-fan status |
| fault_n | output | 1 | Active-low fan failure |

## Verification
A wrong elapsed count appears on `duty_ovr` at the very next tick. It shows as a ramp value off the formula, or as the switch to 0x55 happening one tick early or late. A wrong count of failed attempts only appears at the fifth measurement after a spin-up. A fault may go low too soon, too late, or survive an in-range measurement. For that reason each failure run walks through every attempt and checks `fault_n` after each one. A wrong state shows up in `ovr_sel` one cycle after the strobe or tick that should have moved it.

// File: rtl/fss_pkg.sv
package fss_pkg;

  localparam int ET_W = 14;          // wide enough for the 8000-tick interval
  localparam logic [7:0] DUTY_THIRD = 8'h55;
  localparam logic [7:0] DUTY_FULL  = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SPIN   = 2'd1,
    ST_SETTLE = 2'd2
  } fss_state_t;

  // interval length in millisecond ticks
  function automatic logic [ET_W-1:0] spin_len(input logic [2:0] code);
    case (code)
      3'd0: spin_len = ET_W'(200);
      3'd1: spin_len = ET_W'(400);
      3'd2: spin_len = ET_W'(600);
      3'd3: spin_len = ET_W'(800);
      3'd4: spin_len = ET_W'(1000);
      3'd5: spin_len = ET_W'(2000);
      3'd6: spin_len = ET_W'(4000);
      default: spin_len = ET_W'(8000);
    endcase
  endfunction

  // linear climb over the first third, then full drive
  function automatic logic [7:0] ramp_duty(input logic [ET_W-1:0] e,
                                           input logic [ET_W-1:0] len);
    int unsigned r;
    int unsigned v;
    r = 32'(len) / 3;
    if (32'(e) >= r) begin
      ramp_duty = DUTY_FULL;
    end else begin
      v = 32'(DUTY_THIRD) + (32'd170 * 32'(e)) / r;
      ramp_duty = v[7:0];
    end
  endfunction

endpackage

// File: rtl/fss_spin_timer.sv
module fss_spin_timer
  import fss_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [2:0]      code,
  output logic [ET_W-1:0] elapsed,
  output logic            done
);
  logic [ET_W-1:0] len;

  assign len  = spin_len(code);
  assign done = run & tick & (elapsed == len - ET_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elapsed <= '0;
    else if (!run)    elapsed <= '0;
    else if (tick)    elapsed <= elapsed + ET_W'(1);
  end
endmodule

// File: rtl/fss_fail_track.sv
module fss_fail_track #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic clear,
  input  logic en,
  output logic fault_n
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] fails;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           fails <= '0;
    else if (clear)                       fails <= '0;
    else if (fail && fails != CW'(LIMIT)) fails <= fails + CW'(1);
  end

  assign fault_n = !((fails == CW'(LIMIT)) && en);
endmodule

// File: rtl/fss_status_flag.sv
module fss_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b1;   // reset always begins with a spin-up
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/fan_spinup_supervisor.sv
module fan_spinup_supervisor
  import fss_pkg::*;
#(
  parameter int TACH_W     = 16,
  parameter int FAIL_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              meas_valid,
  input  logic [TACH_W-1:0] tach_period,
  input  logic [TACH_W-1:0] slow_limit,
  input  logic [2:0]        spin_code,
  input  logic              spin_disable,
  input  logic              fault_en,
  input  logic              status_read,
  output logic [7:0]        duty_ovr,
  output logic              ovr_sel,
  output logic              slow_flag,
  output logic              fault_n
);
  fss_state_t      state, state_nx;
  logic [ET_W-1:0] elapsed;
  logic            spin_run, over_limit;
  logic            slow_meas, ok_meas, spin_start, settle_fail, spin_done;

  assign spin_run    = (state == ST_SPIN);
  assign over_limit  = tach_period > slow_limit;
  assign slow_meas   = meas_valid &  over_limit & !spin_run;
  assign ok_meas     = meas_valid & !over_limit & !spin_run;
  assign spin_start  = slow_meas & !spin_disable;
  assign settle_fail = slow_meas & (state == ST_SETTLE);

  fss_spin_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .run(spin_run), .tick(ms_tick),
    .code(spin_code), .elapsed(elapsed), .done(spin_done)
  );

  fss_fail_track #(.LIMIT(FAIL_LIMIT)) u_fail (
    .clk(clk), .rst_n(rst_n), .fail(settle_fail), .clear(ok_meas),
    .en(fault_en), .fault_n(fault_n)
  );

  fss_status_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(slow_meas), .clr(status_read),
    .flag(slow_flag)
  );

  always_comb begin
    state_nx = state;
    if (state == ST_SPIN) begin
      if (spin_done) state_nx = ST_SETTLE;
    end else begin
      if (spin_start)      state_nx = ST_SPIN;
      else if (meas_valid) state_nx = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SPIN;
    else        state <= state_nx;
  end

  always_comb begin
    case (state)
      ST_SPIN: begin
        duty_ovr = ramp_duty(elapsed, spin_len(spin_code));
        ovr_sel  = 1'b1;
      end
      ST_SETTLE: begin
        duty_ovr = DUTY_THIRD;
        ovr_sel  = 1'b1;
      end
      default: begin
        duty_ovr = 8'h00;
        ovr_sel  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fss_checker.sv
module fss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       spin_run,
  input logic       spin_done,
  input logic       slow_meas,
  input logic       ok_meas,
  input logic       spin_disable,
  input logic       status_read,
  input logic       fault_en,
  input logic [2:0] spin_code,
  input logic [7:0] duty_ovr,
  input logic       ovr_sel,
  input logic       slow_flag,
  input logic       fault_n
);
  // R3
  ramp_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spin_run && $past(spin_run) && $stable(spin_code) |-> duty_ovr >= $past(duty_ovr));

  // R4
  settle_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spin_done |=> ovr_sel && duty_ovr == 8'h55);

  // R6
  slow_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_meas |=> slow_flag);

  // R7
  no_spin_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_meas && spin_disable |=> !ovr_sel);

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_read && !slow_meas |=> !slow_flag);

  // R10
  ok_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_meas |=> fault_n);

  // R11
  fault_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_en |-> fault_n);
endmodule

bind fan_spinup_supervisor fss_checker u_fss_chk (
  .clk(clk), .rst_n(rst_n), .spin_run(spin_run), .spin_done(spin_done),
  .slow_meas(slow_meas), .ok_meas(ok_meas), .spin_disable(spin_disable),
  .status_read(status_read), .fault_en(fault_en), .spin_code(spin_code),
  .duty_ovr(duty_ovr), .ovr_sel(ovr_sel), .slow_flag(slow_flag),
  .fault_n(fault_n)
);

// File: tb/test_fan_spinup_supervisor.sv
module test_fan_spinup_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic        meas_valid = 1'b0;
  logic [15:0] tach_period = 16'd0;
  logic [15:0] slow_limit = 16'd1000;
  logic [2:0]  spin_code = 3'd0;
  logic        spin_disable = 1'b0;
  logic        fault_en = 1'b1;
  logic        status_read = 1'b0;
  logic [7:0]  duty_ovr;
  logic        ovr_sel, slow_flag, fault_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fan_spinup_supervisor i_fan_spinup_supervisor (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .meas_valid(meas_valid),
    .tach_period(tach_period), .slow_limit(slow_limit), .spin_code(spin_code),
    .spin_disable(spin_disable), .fault_en(fault_en), .status_read(status_read),
    .duty_ovr(duty_ovr), .ovr_sel(ovr_sel), .slow_flag(slow_flag), .fault_n(fault_n)
  );

  function automatic int exp_len(input int code);
    return (code < 5) ? 200 * (code + 1) : (1000 << (code - 4));
  endfunction

  function automatic int exp_ramp(input int e, input int len);
    int third = len / 3;
    return (e >= third) ? 255 : 85 + (170 * e) / third;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic meas(input int p, input bit rd = 0);
    @(negedge clk);
    tach_period = 16'(p);
    meas_valid = 1'b1;
    status_read = rd;
    @(negedge clk);
    meas_valid = 1'b0;
    status_read = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk) status_read = 1'b1;
    @(negedge clk) status_read = 1'b0;
  endtask

  // R1, R3, R5, R4: reset spin-up with code 0
  task automatic t_reset_spin();
    chk("R1 sel", ovr_sel, 1);
    chk("R1 duty", duty_ovr, 8'h55);
    chk("R1 flag", slow_flag, 1);
    chk("R1 fault_n", fault_n, 1);
    read_status();
    chk("R8 read clears", slow_flag, 0);
    meas(5000);
    chk("R5 flag untouched during spin", slow_flag, 0);
    tick(33);
    chk("R3 e=33", duty_ovr, exp_ramp(33, 200));
    tick(32);
    chk("R3 e=65", duty_ovr, exp_ramp(65, 200));
    tick(1);
    chk("R3 e=66 full", duty_ovr, 255);
    tick(133);
    chk("R2 e=199 still spinning", duty_ovr, 255);
    tick(1);
    chk("R4 settle duty", duty_ovr, 8'h55);
    chk("R4 settle sel", ovr_sel, 1);
    meas(500);
    chk("R4 in range releases sel", ovr_sel, 0);
    chk("R4 duty idle", duty_ovr, 0);
    chk("R10 fault_n", fault_n, 1);
  endtask

  // R7, R8: disabled spin-up and read collision
  task automatic t_disable_flag();
    spin_disable = 1'b1;
    meas(1001);
    chk("R6 slow sets flag", slow_flag, 1);
    chk("R7 no spin", ovr_sel, 0);
    read_status();
    chk("R8 read clears", slow_flag, 0);
    meas(1001, 1);
    chk("R8 set wins over read", slow_flag, 1);
    meas(1000);
    chk("R6 equal is in range", slow_flag, 1);
    chk("R7 still idle", ovr_sel, 0);
    spin_disable = 1'b0;
  endtask

  // R9, R11: five failed attempts then endless retry
  task automatic t_five_fail();
    meas(2000);
    chk("R6 spin starts", ovr_sel, 1);
    chk("R6 spin duty", duty_ovr, 8'h55);
    for (int k = 1; k <= 5; k++) begin
      tick(200);
      meas(2000);
      chk("R9 retry sel", ovr_sel, 1);
      chk("R9 fault_n", fault_n, (k == 5) ? 0 : 1);
    end
    @(negedge clk) fault_en = 1'b0;
    @(negedge clk);
    chk("R11 disabled fault released", fault_n, 1);
    fault_en = 1'b1;
    @(negedge clk);
    chk("R11 re-enabled fault", fault_n, 0);
    tick(200);
    meas(10);
    chk("R10 in range releases fault", fault_n, 1);
    chk("R10 sel dropped", ovr_sel, 0);
  endtask

  // R10: an in-range measurement restarts the count
  task automatic t_count_clear();
    meas(2000);
    for (int k = 0; k < 4; k++) begin tick(200); meas(2000); end
    tick(200);
    meas(10);
    meas(2000);
    for (int k = 0; k < 4; k++) begin tick(200); meas(2000); end
    chk("R10 count restarted", fault_n, 1);
    tick(200);
    meas(2000);
    chk("R9 fifth after restart", fault_n, 0);
    tick(200);
    meas(10);
  endtask

  // R2, R3: longer intervals
  task automatic t_codes();
    spin_code = 3'd1;
    meas(2000);
    tick(66);
    chk("R3 code1 e=66", duty_ovr, exp_ramp(66, exp_len(1)));
    tick(exp_len(1) - 67);
    chk("R2 code1 last tick", duty_ovr, 255);
    tick(1);
    chk("R2 code1 end", duty_ovr, 8'h55);
    meas(10);
    spin_code = 3'd7;
    meas(2000);
    tick(1333);
    chk("R3 code7 e=1333", duty_ovr, exp_ramp(1333, exp_len(7)));
    tick(exp_len(7) - 1334);
    chk("R2 code7 last tick", duty_ovr, 255);
    tick(1);
    chk("R2 code7 end", duty_ovr, 8'h55);
    meas(10);
    chk("R4 code7 released", ovr_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_spin();
    t_disable_flag();
    t_five_fail();
    t_count_clear();
    t_codes();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule